// File: doc/BRIEF.md
# Card Presence Switch Conditioner

This block turns the raw contact of a mechanical card-presence switch into a clean "card inserted" status bit. It also raises a one-cycle event whenever that bit changes, which the interrupt logic uses. A card is counted as inserted only on a rising edge of the switch. Removal is recognised from the switch level instead: the switch has to stay open for a minimum time, measured in microseconds.

Every status change opens a shadow window. During this window the switch is ignored, so contact bounce cannot produce a second change. Short openings while a card is seated are filtered out. A removal that is bounced back to closed during the shadow window does not count as a new insertion, because a fresh rising edge is needed once the window has closed. All timing is counted in ticks of a one-microsecond enable that the system provides. The raw switch passes through a synchroniser before any of this logic sees it.

Top module: `card_detect_filter`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), card_present is 0 and status_evt is 0.
- R2: While card_present is 0 and no shadow window is open, a low-to-high transition of switch_raw (1 = switch closed) sets card_present to 1 within a few clock cycles.
- R3: A switch that is already high when a shadow window closes does not set card_present; only a later low-to-high transition does.
- R4: While card_present is 1, holding switch_raw low for at least MIN_PULSE_US ticks (default 50) clears card_present.
- R5: While card_present is 1, a low pulse shorter than MIN_PULSE_US ticks leaves card_present at 1 and produces no status_evt.
- R6: Every change of card_present opens a shadow window of SHADOW_US ticks (default 1000). During the window, switch activity of any length has no effect on card_present.
- R7: status_evt is high for exactly one clock cycle in the cycle where card_present takes its new value, and it is low at all other times.
- R8: The width measurement starts again from zero whenever the switch returns high, so two short low pulses separated by a high interval do not add up to a removal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| switch_raw | input | 1 | Asynchronous switch contact, 1 = closed (card seated) |
| card_present | output | 1 | Filtered card-inserted status |
| status_evt | output | 1 | One-cycle pulse on each change of card_present |

## Verification
If the controller state is wrong, card_present shows it directly. A missing or early extraction becomes visible as soon as a low pulse crosses the width threshold (55 µs is tested against 45 µs). A shadow window that is too short or missing lets a bounce inside the window flip the status, and this shows within a few cycles of that bounce. An edge detector that fails to re-arm correctly shows up once the window closes. In that case the status either follows a level that was already high, or it misses the next real edge. A width counter that is not cleared when the switch returns high shows up as a false removal after two split pulses.

// File: rtl/cdf_pkg.sv
// Shared types for the card-presence switch conditioner.
package cdf_pkg;
    // Controller states: card out, card seated, shadow window after a change.
    typedef enum logic [1:0] {
        CD_ABSENT  = 2'd0,
        CD_PRESENT = 2'd1,
        CD_HOLD    = 2'd2
    } cd_state_t;
endpackage

// File: rtl/cdf_sync.sv
// Multi-flop synchroniser for the raw switch contact.
// Assumes: the input is asynchronous and changes slowly compared with clk.
// The reset value is 0, meaning switch open.
module cdf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cdf_timer.sv
// Saturating tick counter. It counts us_tick pulses while clr is low and
// flags done once LIMIT ticks have been counted.
// Assumes: clr is held high whenever the interval is not being measured.
module cdf_timer #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] count;

    // Clear, or advance on each tick until the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)               count <= '0;
        else if (tick && (count != LIM)) count <= count + 1'b1;
    end

    assign done = (count == LIM);

    // R4 / R6: the count never passes its limit.
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIM);
endmodule

// File: rtl/cdf_ctrl.sv
// Presence controller. It uses edge-triggered insertion, level-qualified
// extraction and a shadow window after each change.
// Assumes: sw is already synchronised. width_done comes from a timer that
// this block clears unless the card is seated and the switch is low.
// shadow_done comes from a timer that this block clears outside CD_HOLD.
module cdf_ctrl
    import cdf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw,
    input  logic      width_done,
    input  logic      shadow_done,
    output cd_state_t state,
    output logic      inserted,
    output logic      evt
);
    logic sw_d;
    logic rise;

    assign rise = sw & ~sw_d;

    // Previous switch sample. It updates in every state, so the edge
    // detector re-arms without seeing a stale edge when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_d <= 1'b0;
        else        sw_d <= sw;
    end

    // State, status bit and change event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CD_ABSENT;
            inserted <= 1'b0;
            evt      <= 1'b0;
        end else begin
            evt <= 1'b0;
            unique case (state)
                CD_ABSENT: if (rise) begin
                    inserted <= 1'b1;
                    evt      <= 1'b1;
                    state    <= CD_HOLD;
                end
                CD_PRESENT: if (width_done) begin
                    inserted <= 1'b0;
                    evt      <= 1'b1;
                    state    <= CD_HOLD;
                end
                CD_HOLD: if (shadow_done)
                    state <= inserted ? CD_PRESENT : CD_ABSENT;
                default: state <= CD_ABSENT;
            endcase
        end
    end

    // R6: the status is frozen for as long as the shadow window is open.
    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CD_HOLD && !shadow_done) |=> $stable(inserted));
    // R4: a removal needs a completed width measurement.
    a_r4_fall_needs_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inserted) |-> $past(width_done));
    // R2: an insertion needs a synchronised rising edge.
    a_r2_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inserted) |-> $past(sw) && !$past(sw_d));
endmodule

// File: rtl/card_detect_filter.sv
// Top of the card-presence switch conditioner. It connects the
// synchroniser, the two tick timers (pulse width, shadow window) and the
// controller.
// Assumes: us_tick is a one-cycle pulse, once per microsecond.
module card_detect_filter
    import cdf_pkg::*;
#(
    parameter int MIN_PULSE_US = 50,
    parameter int SHADOW_US    = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic switch_raw,
    output logic card_present,
    output logic status_evt
);
    logic      sw;
    logic      width_done;
    logic      shadow_done;
    logic      width_clr;
    logic      shadow_clr;
    cd_state_t state;

    cdf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(switch_raw), .q_sync(sw)
    );

    // Width is measured only while a seated card sees an open switch.
    assign width_clr  = (state != CD_PRESENT) || sw;
    assign shadow_clr = (state != CD_HOLD);

    cdf_timer #(.LIMIT(MIN_PULSE_US)) u_width (
        .clk(clk), .rst_n(rst_n), .clr(width_clr), .tick(us_tick),
        .done(width_done)
    );

    cdf_timer #(.LIMIT(SHADOW_US)) u_shadow (
        .clk(clk), .rst_n(rst_n), .clr(shadow_clr), .tick(us_tick),
        .done(shadow_done)
    );

    cdf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sw(sw), .width_done(width_done),
        .shadow_done(shadow_done), .state(state), .inserted(card_present),
        .evt(status_evt)
    );

    // R7: the event lasts one cycle.
    a_r7_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        status_evt |=> !status_evt);
    // R7: every change of the status comes with the event.
    a_r7_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (card_present != $past(card_present)) |-> status_evt);
    // R7: no event without a change.
    a_r7_evt_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        status_evt |-> (card_present != $past(card_present)));
endmodule

// File: tb/card_detect_filter_test.sv
// Directed bench for card_detect_filter. One task per scenario; us_tick
// fires every second clock, so one microsecond is two clock cycles.
module card_detect_filter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic switch_raw = 1'b0;
    logic card_present;
    logic status_evt;

    int total = 0;
    int bad = 0;
    int evt_cnt = 0;
    int evt_run = 0;
    bit done = 1'b0;

    card_detect_filter uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .switch_raw(switch_raw),
        .card_present(card_present), .status_evt(status_evt)
    );

    always #5 clk = ~clk;

    // Microsecond enable: one clock high, one clock low.
    always @(posedge clk) us_tick <= rst_n ? ~us_tick : 1'b0;

    // Event monitor: counts pulses and flags any pulse longer than a cycle.
    always @(negedge clk) begin
        if (status_evt) begin
            evt_cnt <= evt_cnt + 1;
            evt_run <= evt_run + 1;
            if (evt_run >= 1) begin
                bad <= bad + 1;
                $display("FAIL R7 status_evt width act=%0d exp=1", evt_run + 1);
            end
        end else begin
            evt_run <= 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        switch_raw = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 present", card_present, 0);
        check("R1 evt", status_evt, 0);
        rst_n = 1'b1;
        wait_us(20);
        check("R1 idle present", card_present, 0);
    endtask

    // R2 insertion on an edge, then R6 bounce inside the window ignored.
    task automatic t_insert_and_shadow;
        int e0 = evt_cnt;
        switch_raw = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 insert", card_present, 1);
        check("R7 one evt on insert", evt_cnt - e0, 1);
        switch_raw = 1'b0;
        wait_us(200);
        switch_raw = 1'b1;
        wait_us(10);
        check("R6 bounce in shadow", card_present, 1);
        check("R6 no evt in shadow", evt_cnt - e0, 1);
        wait_us(850);
    endtask

    task automatic t_short_glitch;
        int e0 = evt_cnt;
        switch_raw = 1'b0;
        wait_us(45);
        switch_raw = 1'b1;
        wait_us(10);
        check("R5 short pulse present", card_present, 1);
        check("R5 short pulse evt", evt_cnt - e0, 0);
    endtask

    task automatic t_split_glitch;
        int e0 = evt_cnt;
        switch_raw = 1'b0;
        wait_us(30);
        switch_raw = 1'b1;
        wait_us(5);
        switch_raw = 1'b0;
        wait_us(30);
        switch_raw = 1'b1;
        wait_us(10);
        check("R8 split pulses present", card_present, 1);
        check("R8 split pulses evt", evt_cnt - e0, 0);
    endtask

    task automatic t_extract;
        int e0 = evt_cnt;
        switch_raw = 1'b0;
        wait_us(55);
        check("R4 extract", card_present, 0);
        check("R7 one evt on extract", evt_cnt - e0, 1);
    endtask

    // Bounce back high inside the window; level alone must not reinsert.
    task automatic t_rearm;
        int e0 = evt_cnt;
        wait_us(5);
        switch_raw = 1'b1;
        wait_us(1100);
        check("R3 level after shadow", card_present, 0);
        check("R3 no evt", evt_cnt - e0, 0);
        switch_raw = 1'b0;
        wait_us(5);
        switch_raw = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 fresh edge", card_present, 1);
        check("R7 evt on fresh edge", evt_cnt - e0, 1);
    endtask

    initial begin
        t_reset();
        t_insert_and_shadow();
        t_short_glitch();
        t_split_glitch();
        t_extract();
        t_rearm();
        @(negedge clk);
        done = 1'b1;
    end

    // Watchdog, then the summary line.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog act=timeout exp=finish");
            end
        join_any
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule